// File: doc/BRIEF.md
# Oldest-First Wait/Ready Issue Queue

This block sits between dispatch and execution. It holds up to eight instructions, and each one carries a sequence index that grows by one with program order. An entry is either waiting for its operands or ready to go. A dispatched instruction arrives with a set of flags:

- whether its operands are ready,
- whether it is a load or a store,
- for memory operations, whether the memory unit already accepts it,
- whether it has zero latency or must issue at once.

The queue either sends the instruction straight through on a bypass output, stores it as ready, or stores it as waiting. When the instruction cannot be accepted, the queue reports one of four stall reasons. These are ranked so that a full load queue is reported first, then a full store queue, then a full scheduler buffer, then a reserved dispatch group.

In each cycle the per-slot flags come in from outside, indexed by slot number. They are operand ready, memory ready and resource available. Waiting entries whose operands are ready, and whose memory check passes when they are memory operations, are promoted first. From the promoted entries and the entries already ready, the queue then picks the one with the oldest sequence index whose resources are available. That entry appears on the issue output in the same cycle and leaves the queue at the next clock edge. Age comparison tolerates wraparound of the index.

Top module: `iq_oldest_issue`

## Requirements
- R1: Reset leaves the queue empty. After reset, issue_valid and byp_valid are 0 and stall_code is 0 while no dispatch is offered.
- R2: An accepted dispatch whose operands are ready enters the ready set, provided it is not a memory operation or its memory flag is set, and it has neither the zero-latency nor the must-issue flag. It can issue from the cycle after dispatch, when its slot's resource flag is 1, without any further operand or memory flag.
- R3: An accepted dispatch whose operands are not ready, or which is a memory operation whose memory flag is clear, enters the wait set. It is never issued while it waits, whatever its resource flag is.
- R4: A waiting entry is promoted when its slot's operand flag is 1 and, for a load or store, its slot's memory flag is also 1. Promotion is visible to selection in the same cycle, so an entry can be promoted and issued in one cycle.
- R5: Among the candidates (entries ready or promoted this cycle whose slot resource flag is 1), the one with the oldest sequence index is issued on issue_valid/issue_seq in that cycle. Index a is older than b when (a - b) modulo 256 is 128 or more, with SEQ_W = 8.
- R6: When no candidate exists, issue_valid is 0. A resource flag on a slot that is empty or waiting has no effect.
- R7: An issued entry is removed at the clock edge that ends its issue cycle and is never issued again.
- R8: An accepted dispatch that is ready and has the zero-latency or the must-issue flag appears on byp_valid/byp_seq in its dispatch cycle and is not stored. Without ready operands it goes to the wait set instead and byp_valid stays 0.
- R9: stall_code is 0 for none, 1 for a load with the load queue full, 2 for a store with the store queue full, 3 for a full scheduler buffer and 4 for a reserved dispatch group. When several causes apply, the lowest nonzero code wins. With disp_valid at 0 the code is 0.
- R10: The queue holds 8 entries. A dispatch offered while all 8 are occupied is refused with code 3 (or a higher-ranked code) and is not stored.
- R11: An accepted dispatch that is stored takes the lowest-numbered empty slot. The per-slot flags of that slot number then apply to it.
- R12: A refused dispatch (stall_code not 0) is neither stored nor bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | A dispatch is offered this cycle |
| disp_seq | input | SEQ_W | Sequence index of the offered instruction |
| disp_opnd_rdy | input | 1 | Operands of the offered instruction are ready |
| disp_mem_rdy | input | 1 | Memory unit accepts the offered load/store now |
| disp_load | input | 1 | Offered instruction is a load |
| disp_store | input | 1 | Offered instruction is a store |
| disp_zero_lat | input | 1 | Offered instruction has zero latency |
| disp_must_issue | input | 1 | Offered instruction must issue immediately |
| ldq_full | input | 1 | Load queue has no free slot |
| stq_full | input | 1 | Store queue has no free slot |
| grp_reserved | input | 1 | A dispatch group resource is reserved |
| slot_opnd_rdy | input | DEPTH | Operand-ready flag per slot |
| slot_mem_rdy | input | DEPTH | Memory-ready flag per slot |
| slot_res_ok | input | DEPTH | Resource-available flag per slot |
| issue_valid | output | 1 | An entry is issued this cycle |
| issue_seq | output | SEQ_W | Sequence index of the issued entry |
| byp_valid | output | 1 | Offered instruction bypasses the queue this cycle |
| byp_seq | output | SEQ_W | Sequence index of the bypassed instruction |
| stall_code | output | 3 | Dispatch stall reason, encoded as in R9 |

## Verification
The bench fills slots in patterns where program order and slot order differ, and the oldest ready entry is sometimes blocked by its resource flag. A selector that picks by slot number, or that ignores the resource flag, would then issue the wrong index. It also places entries on both sides of an index wraparound, so a plain magnitude compare would issue 3 before 250. It covers several other cases:

- Promotion and issue in one cycle, and a load held back only by its memory flag. A design that registered promotion, or that ignored the memory flag, would issue one cycle late or too early.
- Reuse of a freed middle slot, to catch allocation that does not take the lowest empty slot.
- Every overlap of the stall causes, including a full queue.
- A refused dispatch or a bypassed dispatch that later issues from the queue; either would show that the design stored something it should not.

// File: rtl/iq_pkg.sv
package iq_pkg;

  typedef enum logic [2:0] {
    STALL_NONE = 3'd0,
    STALL_LDQ  = 3'd1,
    STALL_STQ  = 3'd2,
    STALL_BUF  = 3'd3,
    STALL_GRP  = 3'd4
  } stall_e;

  typedef struct packed {
    logic opnd_rdy;
    logic mem_rdy;
    logic is_load;
    logic is_store;
    logic zero_lat;
    logic must_issue;
  } disp_attr_t;

endpackage

// File: rtl/iq_dispatch_ctrl.sv
module iq_dispatch_ctrl
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  disp_attr_t attr,
  input  logic       ldq_full,
  input  logic       stq_full,
  input  logic       buf_full,
  input  logic       grp_reserved,
  output stall_e     stall,
  output logic       enq,
  output logic       enq_ready,
  output logic       byp
);

  logic is_mem;
  logic opnds_ok;
  logic accept;

  always_comb begin
    is_mem   = attr.is_load | attr.is_store;
    opnds_ok = attr.opnd_rdy & (~is_mem | attr.mem_rdy);

    // ranked causes: lowest code wins
    if (!valid)                        stall = STALL_NONE;
    else if (attr.is_load && ldq_full) stall = STALL_LDQ;
    else if (attr.is_store && stq_full) stall = STALL_STQ;
    else if (buf_full)                 stall = STALL_BUF;
    else if (grp_reserved)             stall = STALL_GRP;
    else                               stall = STALL_NONE;

    accept    = valid & (stall == STALL_NONE);
    byp       = accept & opnds_ok & (attr.zero_lat | attr.must_issue);
    enq       = accept & ~byp;
    enq_ready = opnds_ok;
  end

  assert_ldq_ranked_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && attr.is_load && ldq_full) |-> (stall == STALL_LDQ));

  assert_grp_lowest_rank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall == STALL_GRP) |-> (grp_reserved && !buf_full));

  assert_route_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enq, byp}));

  assert_refused_not_taken_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stall != STALL_NONE) |-> (!enq && !byp));

endmodule

// File: rtl/iq_entry_array.sv
module iq_entry_array #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_ready,
  input  logic                        wr_mem,
  input  logic [SEQ_W-1:0]            wr_seq,
  input  logic                        clr_en,
  input  logic [SLOT_W-1:0]           clr_slot,
  input  logic [DEPTH-1:0]            opnd_rdy,
  input  logic [DEPTH-1:0]            mem_rdy,
  output logic [DEPTH-1:0][SEQ_W-1:0] seq_o,
  output logic [DEPTH-1:0]            avail_o,
  output logic                        full_o
);

  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0]            rdy_q, rdy_d;
  logic [DEPTH-1:0]            mem_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0]            promote;
  logic [DEPTH-1:0]            wr_hit;
  logic [DEPTH-1:0]            clr_hit;
  logic [DEPTH-1:0]            st_en;
  logic [SLOT_W-1:0]           free_slot;

  // lowest empty slot takes the next write
  always_comb begin
    logic found;
    found     = 1'b0;
    free_slot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_slot = SLOT_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign full_o  = &vld_q;
  assign seq_o   = seq_q;
  assign promote = vld_q & ~rdy_q & opnd_rdy & (~mem_q | mem_rdy);
  assign avail_o = vld_q & (rdy_q | promote);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      wr_hit[i]  = wr_en && !full_o && (free_slot == SLOT_W'(i));
      clr_hit[i] = clr_en && (clr_slot == SLOT_W'(i));
      st_en[i]   = wr_hit[i] | clr_hit[i] | promote[i];
      if (wr_hit[i]) begin
        vld_d[i] = 1'b1;
        rdy_d[i] = wr_ready;
      end else if (clr_hit[i]) begin
        vld_d[i] = 1'b0;
        rdy_d[i] = 1'b0;
      end else begin
        vld_d[i] = vld_q[i];
        rdy_d[i] = rdy_q[i] | promote[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        rdy_q[i] <= 1'b0;
      end else if (st_en[i]) begin
        vld_q[i] <= vld_d[i];
        rdy_q[i] <= rdy_d[i];
      end
    end

    always_ff @(posedge clk) begin
      if (wr_hit[i]) begin
        mem_q[i] <= wr_mem;
        seq_q[i] <= wr_seq;
      end
    end

    assert_issued_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[i] |=> !vld_q[i]);

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> (vld_q[i] && seq_q[i] == $past(wr_seq)));

    assert_waiting_not_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[i] && !rdy_q[i] && !opnd_rdy[i]) |-> !avail_o[i]);
  end

endmodule

// File: rtl/iq_age_select.sv
module iq_age_select #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
  output logic                        gnt_valid,
  output logic [SLOT_W-1:0]           gnt_slot,
  output logic [SEQ_W-1:0]            gnt_seq
);

  // a is older than b when a - b wraps negative
  function automatic logic older_f(input logic [SEQ_W-1:0] a,
                                   input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  always_comb begin
    gnt_valid = 1'b0;
    gnt_slot  = '0;
    gnt_seq   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!gnt_valid || older_f(seq[i], gnt_seq))) begin
        gnt_valid = 1'b1;
        gnt_slot  = SLOT_W'(i);
        gnt_seq   = seq[i];
      end
    end
  end

  assert_grant_is_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> cand[gnt_slot]);

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    assert_no_older_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cand[i] && gnt_slot != SLOT_W'(i)) |-> (gnt_valid && !older_f(seq[i], gnt_seq)));
  end

endmodule

// File: rtl/iq_oldest_issue.sv
module iq_oldest_issue
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             disp_opnd_rdy,
  input  logic             disp_mem_rdy,
  input  logic             disp_load,
  input  logic             disp_store,
  input  logic             disp_zero_lat,
  input  logic             disp_must_issue,
  input  logic             ldq_full,
  input  logic             stq_full,
  input  logic             grp_reserved,
  input  logic [DEPTH-1:0] slot_opnd_rdy,
  input  logic [DEPTH-1:0] slot_mem_rdy,
  input  logic [DEPTH-1:0] slot_res_ok,
  output logic             issue_valid,
  output logic [SEQ_W-1:0] issue_seq,
  output logic             byp_valid,
  output logic [SEQ_W-1:0] byp_seq,
  output logic [2:0]       stall_code
);

  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]                  rst_sync_q;
  logic                        rst_i_n;
  disp_attr_t                  attr;
  stall_e                      stall;
  logic                        enq, enq_ready, byp;
  logic                        q_full;
  logic [DEPTH-1:0]            avail;
  logic [DEPTH-1:0]            cand;
  logic [DEPTH-1:0][SEQ_W-1:0] ent_seq;
  logic                        gnt_valid;
  logic [SLOT_W-1:0]           gnt_slot;
  logic [SEQ_W-1:0]            gnt_seq;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_comb begin
    attr.opnd_rdy   = disp_opnd_rdy;
    attr.mem_rdy    = disp_mem_rdy;
    attr.is_load    = disp_load;
    attr.is_store   = disp_store;
    attr.zero_lat   = disp_zero_lat;
    attr.must_issue = disp_must_issue;
  end

  iq_dispatch_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .valid        (disp_valid & rst_i_n),
    .attr         (attr),
    .ldq_full     (ldq_full),
    .stq_full     (stq_full),
    .buf_full     (q_full),
    .grp_reserved (grp_reserved),
    .stall        (stall),
    .enq          (enq),
    .enq_ready    (enq_ready),
    .byp          (byp)
  );

  iq_entry_array #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ents (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (enq),
    .wr_ready (enq_ready),
    .wr_mem   (disp_load | disp_store),
    .wr_seq   (disp_seq),
    .clr_en   (gnt_valid),
    .clr_slot (gnt_slot),
    .opnd_rdy (slot_opnd_rdy),
    .mem_rdy  (slot_mem_rdy),
    .seq_o    (ent_seq),
    .avail_o  (avail),
    .full_o   (q_full)
  );

  assign cand = avail & slot_res_ok;

  iq_age_select #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cand      (cand),
    .seq       (ent_seq),
    .gnt_valid (gnt_valid),
    .gnt_slot  (gnt_slot),
    .gnt_seq   (gnt_seq)
  );

  assign issue_valid = gnt_valid;
  assign issue_seq   = gnt_seq;
  assign byp_valid   = byp;
  assign byp_seq     = disp_seq;
  assign stall_code  = stall;

  assert_full_blocks_enq_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (q_full && disp_valid) |-> (stall_code != 3'd0));

  assert_bypass_not_stored_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    byp_valid |-> !enq);

endmodule

// File: tb/iq_oldest_issue_tb.sv
module iq_oldest_issue_tb;

  localparam int DEPTH = 8;
  localparam int SEQ_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             disp_valid, disp_opnd_rdy, disp_mem_rdy;
  logic             disp_load, disp_store, disp_zero_lat, disp_must_issue;
  logic [SEQ_W-1:0] disp_seq;
  logic             ldq_full, stq_full, grp_reserved;
  logic [DEPTH-1:0] slot_opnd_rdy, slot_mem_rdy, slot_res_ok;
  logic             issue_valid, byp_valid;
  logic [SEQ_W-1:0] issue_seq, byp_seq;
  logic [2:0]       stall_code;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  iq_oldest_issue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_seq(disp_seq),
    .disp_opnd_rdy(disp_opnd_rdy), .disp_mem_rdy(disp_mem_rdy),
    .disp_load(disp_load), .disp_store(disp_store),
    .disp_zero_lat(disp_zero_lat), .disp_must_issue(disp_must_issue),
    .ldq_full(ldq_full), .stq_full(stq_full), .grp_reserved(grp_reserved),
    .slot_opnd_rdy(slot_opnd_rdy), .slot_mem_rdy(slot_mem_rdy),
    .slot_res_ok(slot_res_ok), .issue_valid(issue_valid), .issue_seq(issue_seq),
    .byp_valid(byp_valid), .byp_seq(byp_seq), .stall_code(stall_code)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic put(input int seq, input bit opnd, input bit memr, input bit ld,
                     input bit st, input bit zl, input bit mi);
    disp_valid      = 1'b1;
    disp_seq        = SEQ_W'(seq);
    disp_opnd_rdy   = opnd;
    disp_mem_rdy    = memr;
    disp_load       = ld;
    disp_store      = st;
    disp_zero_lat   = zl;
    disp_must_issue = mi;
  endtask

  task automatic idle();
    disp_valid = 0; disp_seq = '0; disp_opnd_rdy = 0; disp_mem_rdy = 0;
    disp_load = 0; disp_store = 0; disp_zero_lat = 0; disp_must_issue = 0;
    ldq_full = 0; stq_full = 0; grp_reserved = 0;
  endtask

  task automatic quiet_slots();
    slot_opnd_rdy = '0; slot_mem_rdy = '0; slot_res_ok = '0;
  endtask

  task automatic expect_issue(input string req, input int seq);
    check(req, int'(issue_valid), 1);
    check(req, int'(issue_seq), seq);
  endtask

  task automatic t_reset();
    settle();
    check("R1 issue_valid", int'(issue_valid), 0);
    check("R1 byp_valid", int'(byp_valid), 0);
    check("R1 stall_code", int'(stall_code), 0);
    slot_opnd_rdy = '1; slot_mem_rdy = '1; slot_res_ok = '1;
    settle();
    check("R1 empty queue issues nothing", int'(issue_valid), 0);
    tick(); quiet_slots();
  endtask

  task automatic t_ready_path();
    tick(); put(10, 1, 0, 0, 0, 0, 0); settle();
    check("R2 accepted", int'(stall_code), 0);
    check("R2 no bypass", int'(byp_valid), 0);
    tick(); idle(); settle();
    check("R6 no resource no issue", int'(issue_valid), 0);
    tick(); slot_res_ok = '1; settle();
    expect_issue("R2 ready entry issues", 10);
    tick(); settle();
    check("R7 issued once", int'(issue_valid), 0);
    tick(); quiet_slots(); put(31, 1, 1, 0, 1, 0, 0); settle();
    tick(); idle(); slot_res_ok = '1; settle();
    expect_issue("R2 store with memory ok enters ready", 31);
    tick(); settle();
    check("R7 store removed", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_wait_promote();
    tick(); put(20, 0, 0, 0, 0, 0, 0); settle();
    tick(); idle(); slot_res_ok = '1; settle();
    check("R3 waiting not issued", int'(issue_valid), 0);
    tick(); slot_opnd_rdy = 8'h01; settle();
    expect_issue("R4 promote and issue same cycle", 20);
    tick(); settle();
    check("R7 promoted entry removed", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_mem_wait();
    tick(); put(30, 1, 0, 1, 0, 0, 0); settle();
    check("R3 load accepted", int'(stall_code), 0);
    tick(); idle(); slot_opnd_rdy = '1; slot_res_ok = '1; settle();
    check("R4 load held by memory flag", int'(issue_valid), 0);
    tick(); slot_mem_rdy = 8'h01; settle();
    expect_issue("R4 load promoted on memory flag", 30);
    tick(); settle();
    check("R7 load removed", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_oldest();
    tick(); put(50, 1, 0, 0, 0, 0, 0);
    tick(); put(45, 1, 0, 0, 0, 0, 0);
    tick(); put(48, 1, 0, 0, 0, 0, 0);
    tick(); idle(); slot_res_ok = 8'b0000_0101; settle();
    expect_issue("R5 oldest among resource-free", 48);
    tick(); slot_res_ok = '1; settle();
    expect_issue("R5 oldest overall", 45);
    tick(); settle();
    expect_issue("R5 remaining entry", 50);
    tick(); settle();
    check("R7 queue drained", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_wrap();
    tick(); put(3, 1, 0, 0, 0, 0, 0);
    tick(); put(250, 1, 0, 0, 0, 0, 0);
    tick(); idle(); slot_res_ok = '1; settle();
    expect_issue("R5 wrap-aware age", 250);
    tick(); settle();
    expect_issue("R5 wrapped index next", 3);
    tick(); settle();
    check("R7 wrap drained", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_alloc();
    tick(); put(60, 0, 0, 0, 0, 0, 0);
    tick(); put(61, 0, 0, 0, 0, 0, 0);
    tick(); put(62, 0, 0, 0, 0, 0, 0);
    tick(); idle(); slot_opnd_rdy = 8'h02; slot_res_ok = 8'h02; settle();
    expect_issue("R11 slot 1 holds second dispatch", 61);
    tick(); quiet_slots(); put(70, 0, 0, 0, 0, 0, 0); settle();
    check("R11 accepted", int'(stall_code), 0);
    tick(); idle(); slot_opnd_rdy = 8'h02; slot_res_ok = 8'h02; settle();
    expect_issue("R11 freed slot 1 reused", 70);
    tick(); slot_opnd_rdy = '1; slot_res_ok = '1; settle();
    expect_issue("R11 slot 0 remains", 60);
    tick(); settle();
    expect_issue("R11 slot 2 remains", 62);
    tick(); settle();
    check("R7 alloc drained", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_bypass();
    tick(); put(80, 1, 0, 0, 0, 1, 0); settle();
    check("R8 zero-latency bypass", int'(byp_valid), 1);
    check("R8 bypass index", int'(byp_seq), 80);
    tick(); put(81, 1, 0, 0, 0, 0, 1); settle();
    check("R8 must-issue bypass", int'(byp_valid), 1);
    check("R8 bypass index", int'(byp_seq), 81);
    tick(); put(82, 0, 0, 0, 0, 1, 0); settle();
    check("R8 not ready waits", int'(byp_valid), 0);
    tick(); idle(); slot_opnd_rdy = '1; slot_res_ok = '1; settle();
    expect_issue("R8 only waiting one stored", 82);
    tick(); settle();
    check("R8 bypassed not stored", int'(issue_valid), 0);
    quiet_slots();
  endtask

  task automatic t_stall();
    tick(); put(90, 1, 1, 1, 1, 0, 0);
    ldq_full = 1; stq_full = 1; grp_reserved = 1; settle();
    check("R9 load queue first", int'(stall_code), 1);
    ldq_full = 0; settle();
    check("R9 store queue next", int'(stall_code), 2);
    stq_full = 0; settle();
    check("R9 group stall", int'(stall_code), 4);
    disp_load = 0; disp_store = 0; ldq_full = 1; stq_full = 1; settle();
    check("R9 non-memory ignores queue full", int'(stall_code), 4);
    check("R12 no bypass when refused", int'(byp_valid), 0);
    disp_valid = 0; settle();
    check("R9 no offer no code", int'(stall_code), 0);
    tick(); idle(); slot_opnd_rdy = '1; slot_mem_rdy = '1; slot_res_ok = '1; settle();
    check("R12 refused not stored", int'(issue_valid), 0);
    tick(); quiet_slots();
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) begin
      tick(); put(100 + k, 0, 0, 0, 0, 0, 0);
    end
    tick(); put(108, 1, 0, 0, 0, 0, 0); grp_reserved = 1; settle();
    check("R10 full outranks group", int'(stall_code), 3);
    disp_load = 1; ldq_full = 1; settle();
    check("R9 load queue outranks full", int'(stall_code), 1);
    tick(); idle(); slot_opnd_rdy = '1; slot_res_ok = '1;
    for (int k = 0; k < DEPTH; k++) begin
      settle();
      expect_issue("R10 drain in age order", 100 + k);
      tick();
    end
    settle();
    check("R10 ninth not stored", int'(issue_valid), 0);
    quiet_slots();
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    quiet_slots();
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_ready_path();
    t_wait_promote();
    t_mem_wait();
    t_oldest();
    t_wrap();
    t_alloc();
    t_bypass();
    t_stall();
    t_full();
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule